// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block takes a vector of level-sensitive interrupt request lines from peripherals and picks the single most urgent one to present to a processor core. Each source has a 4-bit priority that software writes through a simple register bus. A value of 0 disables the source. A current-priority mask holds back every request whose priority is not strictly above it. Software can raise the mask to a ceiling value around a section that touches a shared resource. Sources at or below the ceiling then cannot preempt that section.

Two vectoring modes are selected by a control bit. In software mode the core always enters one common handler, whose address is the vector base. The handler reads the acknowledge register to learn which source won. In hardware mode the block drives a per-source handler address, base + 16 x source, next to the request. The core accepts it through a valid/ready handshake.

Either form of acknowledge pushes the old mask onto a 16-entry last-in-first-out store and raises the mask to the winner's level. A write to the end-of-interrupt register pops the store and restores the saved mask.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the control bit, vector base, every source priority and the current priority read back as 0, and `core_valid_o` is low.
- R2: A source whose priority is 0 never causes `core_valid_o` to assert, even while its request line is high.
- R3: `core_valid_o` is high only while the winning priority is strictly greater than the current priority. The current priority is written at word address 1, bits [3:0], and reads back from the same address.
- R4: Among requesting enabled sources the highest priority wins. On equal priority the lowest-numbered source wins.
- R5: A request line that rises while the mask allows it causes `core_valid_o` to rise after exactly two rising clock edges. It is still low after the first.
- R6: The vector base is at word address 4, and its bits [3:0] always read 0. In hardware mode (bit 0 of word address 0 = 1), `core_vector_o` = base + 16 x winner. In software mode, `core_vector_o` = base.
- R7: In hardware mode a cycle with `core_valid_o` and `core_ready_i` both high accepts the request: the current priority becomes the winner's priority. While `core_ready_i` is low with unchanged requests, `core_valid_o` and `core_vector_o` stay stable. In software mode `core_ready_i` is ignored.
- R8: Reading word address 2 returns bit 31 = pending and bits [30:0] = winning source number (0 when nothing is pending). In software mode a read with a pending request pushes the current priority and raises it to the winner's level. In hardware mode, or with nothing pending, the read changes no state.
- R9: A write of any value to word address 3 restores the most recently saved current priority (last in, first out). With nothing saved it sets the current priority to 0.
- R10: Source n's priority sits at word address 512 + n, bits [3:0], and is writable and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Level-sensitive request lines, one per source |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| core_valid_o | output | 1 | An unmasked request is pending for the core |
| core_ready_i | input | 1 | Core accepts the request (hardware mode only) |
| core_vector_o | output | 32 | Handler address for the core |

## Verification
On every cycle, the assertions check the following. A full ceiling (15) blocks all requests. No request reaches the core without a line having been high two edges before. Hardware vectors are 16-byte aligned. Every acceptance strictly raises the mask. In software mode the mask never moves without a bus access. Arbitration order, the tie rule, the strict mask comparison, the acknowledge data word, and the nesting and restore of priorities through acknowledge and end-of-interrupt sequences need whole scenarios. The bench's table and directed tests show those.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W       = 4;
  localparam int DATA_W       = 32;
  localparam int VEC_SHIFT    = 4;   // handler stride 16 bytes
  localparam int REG_CTRL     = 0;
  localparam int REG_CUR      = 1;
  localparam int REG_ACK      = 2;
  localparam int REG_EOI      = 3;
  localparam int REG_VBASE    = 4;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 10,
  parameter int SRC_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  prio_t                    cur_i,
  input  logic                     pend_i,
  input  logic [SRC_W-1:0]         win_id_i,
  output logic                     hw_mode_o,
  output logic [DATA_W-1:0]        vbase_o,
  output prio_t [NUM_SRC-1:0]      prio_o,
  output logic                     cur_wr_o,
  output prio_t                    cur_wdata_o,
  output logic                     ack_rd_o,
  output logic                     eoi_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic             wr, rd;
  logic             prio_hit;
  logic [IDX_W-1:0] idx;
  logic             hw_mode_q;
  logic [DATA_W-1:0] vbase_q;
  prio_t [NUM_SRC-1:0] prio_q;
  prio_t            prio_rd;

  assign wr       = sel_i && we_i;
  assign rd       = sel_i && !we_i;
  assign idx      = addr_i[IDX_W-1:0];
  assign prio_hit = addr_i[ADDR_W-1] && (32'(idx) < NUM_SRC);

  assign cur_wr_o    = wr && (32'(addr_i) == REG_CUR);
  assign cur_wdata_o = wdata_i[PRIO_W-1:0];
  assign eoi_o       = wr && (32'(addr_i) == REG_EOI);
  assign ack_rd_o    = rd && (32'(addr_i) == REG_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_mode_q <= 1'b0;
      vbase_q   <= '0;
    end else if (wr) begin
      if (32'(addr_i) == REG_CTRL)  hw_mode_q <= wdata_i[0];
      if (32'(addr_i) == REG_VBASE) vbase_q   <= {wdata_i[DATA_W-1:VEC_SHIFT], {VEC_SHIFT{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (wr && prio_hit) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (idx == IDX_W'(i)) prio_q[i] <= wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    prio_rd = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (idx == IDX_W'(i)) prio_rd = prio_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (prio_hit) begin
      rdata_o[PRIO_W-1:0] = prio_rd;
    end else begin
      case (32'(addr_i))
        REG_CTRL:  rdata_o[0] = hw_mode_q;
        REG_CUR:   rdata_o[PRIO_W-1:0] = cur_i;
        REG_ACK:   rdata_o = pend_i ? {1'b1, (DATA_W-1)'(win_id_i)} : '0;
        REG_VBASE: rdata_o = vbase_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign hw_mode_o = hw_mode_q;
  assign vbase_o   = vbase_q;
  assign prio_o    = prio_q;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int SRC_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  req_i,
  input  prio_t [NUM_SRC-1:0] prio_i,
  output logic                win_valid_o,
  output logic [SRC_W-1:0]    win_id_o,
  output prio_t               win_prio_o
);
  logic [NUM_SRC-1:0]  req_q;
  prio_t [NUM_SRC-1:0] eff_p;
  prio_t               best_p;
  logic [SRC_W-1:0]    best_id;

  // stage 1: capture request levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end

  // an idle or disabled source contributes priority 0
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_eff
    assign eff_p[g] = req_q[g] ? prio_i[g] : '0;
  end

  // strict comparison keeps the lowest index on ties
  always_comb begin
    best_p  = '0;
    best_id = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eff_p[i] > best_p) begin
        best_p  = eff_p[i];
        best_id = SRC_W'(i);
      end
    end
  end

  // stage 2: registered winner
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_o <= 1'b0;
      win_id_o    <= '0;
      win_prio_o  <= '0;
    end else begin
      win_valid_o <= (best_p != '0);
      win_id_o    <= best_id;
      win_prio_o  <= best_p;
    end
  end
endmodule

// File: rtl/intc_stack.sv
module intc_stack
  import intc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  prio_t push_prio_i,
  input  logic  pop_i,
  input  logic  wr_i,
  input  prio_t wr_val_i,
  output prio_t cur_o
);
  prio_t              cur_q;
  prio_t [DEPTH-1:0]  stk_q;

  // shift-register LIFO: empty slots hold 0, oldest entry drops on overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
    end else if (push_i && !pop_i) begin
      stk_q[0] <= cur_q;
      for (int i = 1; i < DEPTH; i++) stk_q[i] <= stk_q[i-1];
    end else if (pop_i && !push_i) begin
      for (int i = 0; i < DEPTH-1; i++) stk_q[i] <= stk_q[i+1];
      stk_q[DEPTH-1] <= '0;
    end
  end

  // acknowledge outranks end-of-interrupt, which outranks a mask write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (push_i) cur_q <= push_prio_i;
    else if (pop_i)  cur_q <= stk_q[0];
    else if (wr_i)   cur_q <= wr_val_i;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC    = 32,
  parameter int ADDR_W     = 10,
  parameter int LIFO_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               core_valid_o,
  input  logic               core_ready_i,
  output logic [31:0]        core_vector_o
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             hw_mode;
  logic [31:0]      vbase;
  prio_t [NUM_SRC-1:0] prio;
  logic             cur_wr, ack_rd, eoi_wr;
  prio_t            cur_wval, cur_prio, win_prio;
  logic             win_valid, accept;
  logic [SRC_W-1:0] win_id;

  intc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .cur_i(cur_prio), .pend_i(core_valid_o), .win_id_i(win_id),
    .hw_mode_o(hw_mode), .vbase_o(vbase), .prio_o(prio),
    .cur_wr_o(cur_wr), .cur_wdata_o(cur_wval),
    .ack_rd_o(ack_rd), .eoi_o(eoi_wr)
  );

  intc_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .req_i(irq_src_i), .prio_i(prio),
    .win_valid_o(win_valid), .win_id_o(win_id), .win_prio_o(win_prio)
  );

  intc_stack #(.DEPTH(LIFO_DEPTH)) stack_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(accept), .push_prio_i(win_prio), .pop_i(eoi_wr),
    .wr_i(cur_wr), .wr_val_i(cur_wval), .cur_o(cur_prio)
  );

  assign core_valid_o = win_valid && (win_prio > cur_prio);
  assign accept = core_valid_o && (hw_mode ? core_ready_i : ack_rd);
  assign core_vector_o = hw_mode
    ? vbase + {{(32-SRC_W-VEC_SHIFT){1'b0}}, win_id, {VEC_SHIFT{1'b0}}}
    : vbase;
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_any,
  input logic        hw_mode,
  input logic        accept,
  input logic        ack_rd,
  input logic        eoi_wr,
  input logic        cur_wr,
  input prio_t       cur_prio,
  input logic        core_valid,
  input logic [31:0] core_vector
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (cur_prio == '0 && !core_valid));

  a_r3_ceiling_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_prio == '1) |-> !core_valid);

  a_r5_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> $past(req_any, 2));

  a_r6_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && core_valid) |-> (core_vector[VEC_SHIFT-1:0] == '0));

  a_r7_accept_raises: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cur_prio > $past(cur_prio)));

  a_r7_sw_ready_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode && !ack_rd && !eoi_wr && !cur_wr) |=> $stable(cur_prio));
endmodule

bind prio_vec_intc intc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .req_any(|irq_src_i), .hw_mode(hw_mode),
  .accept(accept), .ack_rd(ack_rd), .eoi_wr(eoi_wr), .cur_wr(cur_wr),
  .cur_prio(cur_prio), .core_valid(core_valid_o), .core_vector(core_vector_o)
);

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
  localparam int N = 32;
  localparam int AW = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  typedef struct packed {
    logic [31:0] req;
    logic [3:0]  mask;
    logic        ev;
    logic [4:0]  eid;
  } vec_t;

  // source n has priority n % 16
  localparam vec_t TBL [11] = '{
    '{32'h0000_0000, 4'd0,  1'b0, 5'd0},   // R3 nothing requested
    '{32'h0000_0008, 4'd0,  1'b1, 5'd3},   // R4 single
    '{32'h0000_0028, 4'd0,  1'b1, 5'd5},   // R4 higher wins
    '{32'h0020_0020, 4'd0,  1'b1, 5'd5},   // R4 tie lowest id
    '{32'h0001_0001, 4'd0,  1'b0, 5'd0},   // R2 priority 0 sources
    '{32'h8000_8000, 4'd0,  1'b1, 5'd15},  // R4 tie at top level
    '{32'h0000_0080, 4'd7,  1'b0, 5'd0},   // R3 equal to mask
    '{32'h0000_0080, 4'd6,  1'b1, 5'd7},   // R3 just above
    '{32'h0000_0204, 4'd8,  1'b1, 5'd9},   // R3 mask 8
    '{32'h0000_0204, 4'd9,  1'b0, 5'd0},   // R3 mask 9
    '{32'h4000_4000, 4'd13, 1'b1, 5'd14}   // R4 tie above mask
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          sel = 1'b0, we = 1'b0, rdy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0, rdata, vec;
  logic          valid;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_vec_intc #(.NUM_SRC(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .core_valid_o(valid), .core_ready_i(rdy), .core_vector_o(vec)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    // R1 state inside reset and after release
    check(valid == 1'b0, "R1 valid", 32'(valid), 0);
    rst_n = 1'b1;
    wait_cyc(1);
    bus_read(0, d);  check(d == 0, "R1 ctrl", d, 0);
    bus_read(1, d);  check(d == 0, "R1 cur", d, 0);
    bus_read(4, d);  check(d == 0, "R1 vbase", d, 0);
    bus_read(512 + 7, d); check(d == 0, "R1 prio", d, 0);

    // setup: hardware mode, base, priorities
    bus_write(0, 32'd1);
    bus_write(4, BASE | 32'h7);
    bus_read(4, d);  check(d == BASE, "R6 vbase low bits", d, BASE);
    for (int n = 0; n < N; n++) bus_write(512 + n, 32'(n % 16));
    bus_read(512 + 13, d); check(d == 32'd13, "R10 prio readback", d, 13);

    // table walk in hardware mode with ready low
    for (int k = 0; k < 11; k++) begin
      irq = TBL[k].req;
      bus_write(1, 32'(TBL[k].mask));
      wait_cyc(2);
      check(valid == TBL[k].ev, "R3/R4 valid", 32'(valid), 32'(TBL[k].ev));
      if (TBL[k].ev) begin
        check(vec == BASE + 32'(TBL[k].eid) * 16, "R6 hw vector", vec, BASE + 32'(TBL[k].eid) * 16);
        bus_read(2, d);
        check(d == {1'b1, 26'd0, TBL[k].eid}, "R8 ack data", d, {1'b1, 26'd0, TBL[k].eid});
      end
      bus_read(1, d);
      check(d == 32'(TBL[k].mask), "R8 hw ack read no effect", d, 32'(TBL[k].mask));
    end

    // R5 latency
    irq = '0;
    bus_write(1, 0);
    wait_cyc(3);
    irq = 32'h0000_0008;
    wait_cyc(1);
    check(valid == 1'b0, "R5 after one edge", 32'(valid), 0);
    wait_cyc(1);
    check(valid == 1'b1, "R5 after two edges", 32'(valid), 1);

    // R7 back-pressure then accept
    d = vec;
    wait_cyc(3);
    check(valid && vec == d, "R7 stable under stall", vec, d);
    rdy = 1'b1;
    wait_cyc(1);
    rdy = 1'b0;
    check(valid == 1'b0, "R7 masked after accept", 32'(valid), 0);
    bus_read(1, d); check(d == 32'd3, "R7 cur raised", d, 3);
    bus_write(3, 0);
    check(valid == 1'b1, "R9 restore unmasks", 32'(valid), 1);
    bus_read(1, d); check(d == 0, "R9 cur restored", d, 0);

    // software mode
    bus_write(0, 32'd0);
    irq = 32'h0000_0208;
    wait_cyc(3);
    check(vec == BASE, "R6 sw vector", vec, BASE);
    rdy = 1'b1;
    wait_cyc(2);
    rdy = 1'b0;
    bus_read(1, d); check(d == 0, "R7 ready ignored in sw", d, 0);
    bus_read(2, d); check(d == 32'h8000_0009, "R8 sw ack", d, 32'h8000_0009);
    bus_read(1, d); check(d == 32'd9, "R8 cur raised", d, 9);
    check(valid == 1'b0, "R3 masked after ack", 32'(valid), 0);
    irq = 32'h0000_1208;
    wait_cyc(3);
    bus_read(2, d); check(d == 32'h8000_000C, "R8 nested ack", d, 32'h8000_000C);
    bus_read(1, d); check(d == 32'd12, "R8 cur nested", d, 12);
    bus_write(3, 0);
    bus_read(1, d); check(d == 32'd9, "R9 first pop", d, 9);
    bus_write(3, 0);
    bus_read(1, d); check(d == 0, "R9 second pop", d, 0);
    bus_write(3, 0);
    bus_read(1, d); check(d == 0, "R9 empty pop", d, 0);
    check(valid == 1'b1, "R4 pending again", 32'(valid), 1);

    // R8 ack with nothing pending
    irq = '0;
    wait_cyc(3);
    bus_read(2, d); check(d == 0, "R8 idle ack data", d, 0);
    bus_read(1, d); check(d == 0, "R8 idle ack no effect", d, 0);

    // R2 disabling a source
    irq = 32'h0000_1000;
    bus_write(512 + 12, 0);
    wait_cyc(3);
    check(valid == 1'b0, "R2 disabled source", 32'(valid), 0);

    finish_run();
  end
endmodule